// File: doc/BRIEF.md
# Memory Power-Down Timing Guard

This block sits between the command scheduler of a DDR3-class memory controller and the pins that carry commands and the clock-enable level. It watches every command the scheduler issues and every change of the clock-enable (CKE) level. From these it reports, cycle by cycle, whether the controller may drop CKE to enter power-down, whether it may raise CKE to leave power-down, and whether a command may follow an exit. A command that needs a locked DLL and one that does not are reported separately.

Each command type imposes its own wait before CKE may fall. The write waits depend on the burst mode and on auto-precharge. All waits run at the same time, and the one that ends last decides. The block also enforces the minimum time CKE must hold a level. It flags a device that stays powered down longer than the allowed residency.

All limits arrive as clock counts. Any limit given in nanoseconds is rounded up to whole clocks when the controller is configured. The outputs depend only on registered state, so the scheduler can use them in the same cycle without a combinational path from its own command.

Top module: `pd_timing_guard`

## Requirements
- R1: Command codes on `cmd_code` are ACT=0, PRE=1, REF=2, MRS=3, RD=4, RDA=5, WR=6, WRA=7. A command accepted (`cmd_valid`=1) in cycle t with wait D keeps `pde_allowed` low from cycle t+1 through t+D-1. ACT, PRE and REF have D=1, so they never hold `pde_allowed` low.
- R2: RD and RDA have D = `cfg_rl` + 5.
- R3: `burst_mode` is 0 for fixed BL8, 1 for on-the-fly and 3 for reserved (treated as BL8). With any of these, WR has D = `cfg_wl` + 4 + `cfg_twr` and WRA has D = `cfg_wl` + 4 + `cfg_wr` + 1.
- R4: With `burst_mode`=2 (fixed BC4), WR has D = `cfg_wl` + 2 + `cfg_twr` and WRA has D = `cfg_wl` + 2 + `cfg_wr` + 1.
- R5: MRS has D = `cfg_tmod`, with a floor of 1.
- R6: When several waits overlap, `pde_allowed` stays low until the latest of their end cycles has passed. It also needs CKE high in the previous cycle and the hold time of R7 met.
- R7: If `cke_in` takes a new level in cycle c, then `pde_allowed` and `pdx_allowed` are both low in cycles c+1 through c+`cfg_tcke`-1. `pdx_allowed` is high only when CKE was low in the previous cycle and the hold time has passed. The two are never high together.
- R8: If `cke_in` rises in cycle e, then `cmd_allowed_nodll` is high from cycle e+`cfg_txp` and `cmd_allowed_dll` is high from cycle e+`cfg_txpdll`. Both are low in any cycle whose previous cycle had CKE low.
- R9: `pd_residency_viol` is high in a cycle exactly when the run of consecutive CKE-low cycles ending in the previous cycle is longer than `cfg_pd_max`. It clears in the cycle after CKE is seen high.
- R10: After reset, `pde_allowed`=1, `pdx_allowed`=0, `cmd_allowed_nodll`=1, `cmd_allowed_dll`=1 and `pd_residency_viol`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 3 | Command type of the issued command |
| burst_mode | input | 2 | Burst length setting from the mode register |
| cfg_rl | input | CNT_W | Read latency in clocks |
| cfg_wl | input | CNT_W | Write latency in clocks |
| cfg_twr | input | CNT_W | Write recovery time rounded up to clocks |
| cfg_wr | input | CNT_W | Write recovery value programmed for auto-precharge |
| cfg_tmod | input | CNT_W | Mode-register-set to next action, in clocks |
| cfg_tcke | input | CNT_W | Minimum CKE level hold, in clocks |
| cfg_txp | input | CNT_W | Exit to command not needing a locked DLL, in clocks |
| cfg_txpdll | input | CNT_W | Exit to command needing a locked DLL, in clocks |
| cfg_pd_max | input | RES_W | Longest allowed power-down residency, in clocks |
| cke_in | input | 1 | CKE level driven to the device this cycle |
| pde_allowed | output | 1 | CKE may be driven low this cycle |
| pdx_allowed | output | 1 | CKE may be driven high this cycle |
| cmd_allowed_nodll | output | 1 | A command not needing a locked DLL may issue |
| cmd_allowed_dll | output | 1 | A command needing a locked DLL may issue |
| pd_residency_viol | output | 1 | Power-down has lasted longer than allowed |

## Verification
A command seen at one clock edge affects `pde_allowed` from the next cycle. The flag stays low for its wait minus one cycle and rises in the cycle that ends the wait. A CKE change blocks both CKE permissions for the hold time minus one cycle. A rising CKE opens the two command permissions after the exit delays. The residency flag follows the low run by one cycle. The bench drives its inputs on the falling edge and then samples all five outputs before the next falling edge. It compares them with a reference that stores the cycle number of each command, each CKE change and each exit, so every result is checked in the exact cycle it is due. Directed runs count the cycles from each command type until `pde_allowed` rises, for every burst mode.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

    typedef enum logic [2:0] {
        PC_ACT = 3'd0,
        PC_PRE = 3'd1,
        PC_REF = 3'd2,
        PC_MRS = 3'd3,
        PC_RD  = 3'd4,
        PC_RDA = 3'd5,
        PC_WR  = 3'd6,
        PC_WRA = 3'd7
    } pd_cmd_e;

    typedef enum logic [1:0] {
        BM_BL8 = 2'd0,
        BM_OTF = 2'd1,
        BM_BC4 = 2'd2,
        BM_RSV = 2'd3
    } burst_mode_e;

    // Exit timers kept as an indexed set
    localparam int EXIT_TIMERS = 2;
    localparam int EX_NODLL    = 0;
    localparam int EX_DLL      = 1;

    typedef struct packed {
        logic pde;
        logic pdx;
        logic nodll;
        logic dll;
        logic viol;
    } pd_status_t;

    // Clocks from a command until CKE may fall (at least 1)
    function automatic int unsigned pd_entry_delay(
        input pd_cmd_e     code,
        input burst_mode_e mode,
        input int unsigned rl,
        input int unsigned wl,
        input int unsigned twr_ck,
        input int unsigned wr,
        input int unsigned tmod
    );
        int unsigned span;
        int unsigned d;
        span = (mode == BM_BC4) ? 32'd2 : 32'd4;
        case (code)
            PC_RD, PC_RDA: d = rl + 32'd5;
            PC_WR:         d = wl + span + twr_ck;
            PC_WRA:        d = wl + span + wr + 32'd1;
            PC_MRS:        d = tmod;
            default:       d = 32'd1;
        endcase
        if (d == 32'd0) d = 32'd1;
        return d;
    endfunction

endpackage

// File: rtl/pdg_down_timer.sv
module pdg_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] span,
    output logic         expired
);
    // span is the full wait in clocks; the counter holds span-1 after a load
    logic [W-1:0] cnt;
    logic [W-1:0] start;

    always_comb begin
        start = (span == '0) ? '0 : span - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= start;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pdg_entry_tracker.sv
module pdg_entry_tracker
    import pdg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [1:0]       burst_mode,
    input  logic [CNT_W-1:0] cfg_rl,
    input  logic [CNT_W-1:0] cfg_wl,
    input  logic [CNT_W-1:0] cfg_twr,
    input  logic [CNT_W-1:0] cfg_wr,
    input  logic [CNT_W-1:0] cfg_tmod,
    output logic             entry_clear
);
    localparam int DLY_W = CNT_W + 2;

    logic [DLY_W-1:0] remain;
    logic [DLY_W-1:0] remain_dec;
    logic [DLY_W-1:0] need;

    always_comb begin
        remain_dec = (remain == '0) ? '0 : remain - 1'b1;
        need = DLY_W'(pd_entry_delay(pd_cmd_e'(cmd_code), burst_mode_e'(burst_mode),
                                     int'(cfg_rl), int'(cfg_wl), int'(cfg_twr),
                                     int'(cfg_wr), int'(cfg_tmod))) - 1'b1;
    end

    // Keep whichever outstanding wait finishes last
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (cmd_valid && (need > remain_dec)) begin
            remain <= need;
        end else begin
            remain <= remain_dec;
        end
    end

    assign entry_clear = (remain == '0);
endmodule

// File: rtl/pdg_residency.sv
module pdg_residency #(
    parameter int RES_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke_in,
    input  logic [RES_W-1:0] cfg_pd_max,
    output logic             over_limit
);
    logic [RES_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || cke_in) begin
            low_run <= '0;
        end else if (low_run != '1) begin
            low_run <= low_run + 1'b1;
        end
    end

    assign over_limit = (low_run > cfg_pd_max);
endmodule

// File: rtl/pd_timing_guard.sv
module pd_timing_guard
    import pdg_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int RES_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [1:0]       burst_mode,
    input  logic [CNT_W-1:0] cfg_rl,
    input  logic [CNT_W-1:0] cfg_wl,
    input  logic [CNT_W-1:0] cfg_twr,
    input  logic [CNT_W-1:0] cfg_wr,
    input  logic [CNT_W-1:0] cfg_tmod,
    input  logic [CNT_W-1:0] cfg_tcke,
    input  logic [CNT_W-1:0] cfg_txp,
    input  logic [CNT_W-1:0] cfg_txpdll,
    input  logic [RES_W-1:0] cfg_pd_max,
    input  logic             cke_in,
    output logic             pde_allowed,
    output logic             pdx_allowed,
    output logic             cmd_allowed_nodll,
    output logic             cmd_allowed_dll,
    output logic             pd_residency_viol
);
    logic cke_q;
    logic cke_edge;
    logic cke_rise;
    logic entry_clear;
    logic hold_clear;
    logic over_limit;
    logic [EXIT_TIMERS-1:0]            exit_clear;
    logic [EXIT_TIMERS-1:0][CNT_W-1:0] exit_span;
    pd_status_t st;

    always_ff @(posedge clk) begin
        if (rst) cke_q <= 1'b1;
        else     cke_q <= cke_in;
    end

    assign cke_edge = cke_in ^ cke_q;
    assign cke_rise = cke_in & ~cke_q;

    pdg_entry_tracker #(.CNT_W(CNT_W)) u_entry (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .burst_mode (burst_mode),
        .cfg_rl     (cfg_rl),
        .cfg_wl     (cfg_wl),
        .cfg_twr    (cfg_twr),
        .cfg_wr     (cfg_wr),
        .cfg_tmod   (cfg_tmod),
        .entry_clear(entry_clear)
    );

    pdg_down_timer #(.W(CNT_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (cke_edge),
        .span   (cfg_tcke),
        .expired(hold_clear)
    );

    assign exit_span[EX_NODLL] = cfg_txp;
    assign exit_span[EX_DLL]   = cfg_txpdll;

    for (genvar g = 0; g < EXIT_TIMERS; g++) begin : g_exit
        pdg_down_timer #(.W(CNT_W)) u_exit (
            .clk    (clk),
            .rst    (rst),
            .load   (cke_rise),
            .span   (exit_span[g]),
            .expired(exit_clear[g])
        );
    end

    pdg_residency #(.RES_W(RES_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .cke_in    (cke_in),
        .cfg_pd_max(cfg_pd_max),
        .over_limit(over_limit)
    );

    always_comb begin
        st.pde   = cke_q & hold_clear & entry_clear;
        st.pdx   = ~cke_q & hold_clear;
        st.nodll = cke_q & exit_clear[EX_NODLL];
        st.dll   = cke_q & exit_clear[EX_DLL];
        st.viol  = over_limit;
    end

    assign pde_allowed       = st.pde;
    assign pdx_allowed       = st.pdx;
    assign cmd_allowed_nodll = st.nodll;
    assign cmd_allowed_dll   = st.dll;
    assign pd_residency_viol = st.viol;
endmodule

// File: rtl/pdg_checker.sv
module pdg_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic [2:0]       cmd_code,
    input logic             cke_in,
    input logic [CNT_W-1:0] cfg_tcke,
    input logic [CNT_W-1:0] cfg_txp,
    input logic [CNT_W-1:0] cfg_txpdll,
    input logic             pde_allowed,
    input logic             pdx_allowed,
    input logic             cmd_allowed_nodll,
    input logic             cmd_allowed_dll,
    input logic             pd_residency_viol
);
    // R2: a read always needs more than one clock before entry
    a_r2_read_blocks_entry: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_code == 3'd4 || cmd_code == 3'd5)) |=> !pde_allowed);

    // R3 and R4: a write always needs more than one clock before entry
    a_r3_write_blocks_entry: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_code == 3'd6 || cmd_code == 3'd7)) |=> !pde_allowed);

    // R7: a CKE change closes both CKE permissions for the next cycle
    a_r7_hold_after_change: assert property (@(posedge clk) disable iff (rst)
        (cfg_tcke > 1 && cke_in != $past(cke_in)) |=> (!pde_allowed && !pdx_allowed));

    // R7: entry and exit permissions never coincide
    a_r7_entry_exit_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pde_allowed && pdx_allowed));

    // R8: no command permission while the device was powered down
    a_r8_no_cmd_in_pd: assert property (@(posedge clk) disable iff (rst)
        !$past(cke_in) |-> (!cmd_allowed_nodll && !cmd_allowed_dll));

    // R8: with the longer DLL delay, the DLL permission implies the other
    a_r8_dll_implies_nodll: assert property (@(posedge clk) disable iff (rst)
        (cfg_txpdll >= cfg_txp && cmd_allowed_dll) |-> cmd_allowed_nodll);

    // R9: the residency flag only follows a low CKE cycle
    a_r9_viol_only_in_pd: assert property (@(posedge clk) disable iff (rst)
        pd_residency_viol |-> !$past(cke_in));
endmodule

bind pd_timing_guard pdg_checker #(.CNT_W(CNT_W)) u_pdg_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_valid        (cmd_valid),
    .cmd_code         (cmd_code),
    .cke_in           (cke_in),
    .cfg_tcke         (cfg_tcke),
    .cfg_txp          (cfg_txp),
    .cfg_txpdll       (cfg_txpdll),
    .pde_allowed      (pde_allowed),
    .pdx_allowed      (pdx_allowed),
    .cmd_allowed_nodll(cmd_allowed_nodll),
    .cmd_allowed_dll  (cmd_allowed_dll),
    .pd_residency_viol(pd_residency_viol)
);

// File: tb/sim_pd_timing_guard.sv
module sim_pd_timing_guard;
    localparam int CNT_W = 6;
    localparam int RES_W = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [1:0] burst_mode = 2'd0;
    logic [CNT_W-1:0] cfg_rl, cfg_wl, cfg_twr, cfg_wr, cfg_tmod;
    logic [CNT_W-1:0] cfg_tcke, cfg_txp, cfg_txpdll;
    logic [RES_W-1:0] cfg_pd_max;
    logic cke_in = 1'b1;
    logic pde_allowed, pdx_allowed, cmd_allowed_nodll, cmd_allowed_dll, pd_residency_viol;

    always #5 clk = ~clk;

    pd_timing_guard #(.CNT_W(CNT_W), .RES_W(RES_W)) u0 (.*);

    int checks = 0;
    int errors = 0;
    // reference model state, all in cycle numbers
    int n, ready, chg, ex, lowrun, lvl;
    int rl, wl, twr, wr, tmod, tcke, txp, txpdll, pdmax, bm;
    logic obs_pde, obs_viol;

    function automatic int cdiv(input int ps, input int tck_ps);
        return (ps + tck_ps - 1) / tck_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int dly(input int code);
        int span = (bm == 2) ? 2 : 4;
        int d;
        case (code)
            4, 5:    d = rl + 5;
            6:       d = wl + span + twr;
            7:       d = wl + span + wr + 1;
            3:       d = imax(tmod, 1);
            default: d = 1;
        endcase
        return d;
    endfunction

    function automatic bit e_pde();  return n >= ready && lvl == 1 && n >= chg + tcke; endfunction
    function automatic bit e_pdx();  return lvl == 0 && n >= chg + tcke; endfunction
    function automatic bit e_nd();   return lvl == 1 && n >= ex + txp; endfunction
    function automatic bit e_dll();  return lvl == 1 && n >= ex + txpdll; endfunction
    function automatic bit e_viol(); return lowrun > pdmax; endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, n, act, exp);
        end
    endtask

    task automatic step(input bit v, input int code, input bit ck);
        @(negedge clk);
        chk("R6 pde_allowed", int'(pde_allowed), int'(e_pde()));
        chk("R7 pdx_allowed", int'(pdx_allowed), int'(e_pdx()));
        chk("R8 cmd_allowed_nodll", int'(cmd_allowed_nodll), int'(e_nd()));
        chk("R8 cmd_allowed_dll", int'(cmd_allowed_dll), int'(e_dll()));
        chk("R9 pd_residency_viol", int'(pd_residency_viol), int'(e_viol()));
        obs_pde = pde_allowed;
        obs_viol = pd_residency_viol;
        cmd_valid = v;
        cmd_code = 3'(code);
        cke_in = ck;
        if (v) ready = imax(ready, n + dly(code));
        if (int'(ck) != lvl) begin
            chg = n;
            if (ck) ex = n;
        end
        lvl = ck;
        lowrun = ck ? 0 : lowrun + 1;
        n++;
    endtask

    task automatic apply_cfg(input int tck_ps, input int rl_v, input int wl_v, input int pdm);
        rl = rl_v; wl = wl_v;
        twr = cdiv(15000, tck_ps); wr = twr;
        tmod = imax(12, cdiv(15000, tck_ps));
        tcke = imax(3, cdiv(5625, tck_ps));
        txp = imax(3, cdiv(7500, tck_ps));
        txpdll = imax(10, cdiv(24000, tck_ps));
        pdmax = pdm;
        cfg_rl = CNT_W'(rl); cfg_wl = CNT_W'(wl); cfg_twr = CNT_W'(twr);
        cfg_wr = CNT_W'(wr); cfg_tmod = CNT_W'(tmod); cfg_tcke = CNT_W'(tcke);
        cfg_txp = CNT_W'(txp); cfg_txpdll = CNT_W'(txpdll); cfg_pd_max = RES_W'(pdmax);
    endtask

    task automatic do_reset();
        rst = 1'b1; cmd_valid = 1'b0; cke_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: register reset values visible before the first active edge
        chk("R10 reset pde", int'(pde_allowed), 1);
        chk("R10 reset pdx", int'(pdx_allowed), 0);
        chk("R10 reset nodll", int'(cmd_allowed_nodll), 1);
        chk("R10 reset dll", int'(cmd_allowed_dll), 1);
        chk("R10 reset viol", int'(pd_residency_viol), 0);
        n = 0; ready = 0; chg = -1000; ex = -1000; lowrun = 0; lvl = 1;
    endtask

    task automatic settle();
        while (!(e_pde() && e_dll())) step(0, 0, 1);
    endtask

    task automatic measure(input int code, input string tag);
        int k;
        int d;
        settle();
        d = dly(code);
        step(1, code, 1);
        k = 0;
        do begin step(0, 0, 1); k++; end while (!obs_pde && k < 300);
        chk(tag, k, d);
    endtask

    task automatic directed();
        for (int m = 0; m < 4; m++) begin
            bm = m; burst_mode = 2'(m);
            measure(0, "R1 ACT wait");
            measure(1, "R1 PRE wait");
            measure(2, "R1 REF wait");
            measure(4, "R2 RD wait");
            measure(5, "R2 RDA wait");
            measure(3, "R5 MRS wait");
            if (m == 2) begin
                measure(6, "R4 BC4 WR wait");
                measure(7, "R4 BC4 WRA wait");
            end else begin
                measure(6, "R3 WR wait");
                measure(7, "R3 WRA wait");
            end
        end
        // R6: a short wait after a long one does not shorten it
        begin
            int k;
            settle();
            step(1, 6, 1);
            step(1, 0, 1);
            k = 1;
            do begin step(0, 0, 1); k++; end while (!obs_pde && k < 300);
            chk("R6 longest wait wins", k, dly(6));
        end
        // R9: overstay in power-down raises the flag
        begin
            bit seen = 0;
            settle();
            step(0, 0, 0);
            repeat (pdmax + 3) begin step(0, 0, 0); if (obs_viol) seen = 1; end
            chk("R9 overstay flagged", int'(seen), 1);
            while (!e_pdx()) step(0, 0, 0);
            step(0, 0, 1);
            step(0, 0, 1);
            chk("R9 flag clears after exit", int'(obs_viol), 0);
        end
    endtask

    task automatic random_run(input int cycles);
        int target = 0;
        for (int i = 0; i < cycles; i++) begin
            if (i % 500 == 0) begin
                bm = $urandom_range(0, 3);
                burst_mode = 2'(bm);
            end
            if (lvl == 1) begin
                if (e_dll() && $urandom_range(0, 99) < 30)
                    step(1, $urandom_range(0, 7), 1);
                else if (e_pde() && $urandom_range(0, 99) < 4) begin
                    target = $urandom_range(1, pdmax + 15);
                    step(0, 0, 0);
                end else
                    step(0, 0, 1);
            end else begin
                if (e_pdx() && lowrun >= target) step(0, 0, 1);
                else step(0, 0, 0);
            end
        end
    endtask

    initial begin
        apply_cfg(1500, 9, 7, 40);
        do_reset();
        directed();
        random_run(3000);
        apply_cfg(2500, 6, 5, 25);
        do_reset();
        directed();
        random_run(3000);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule